// File: doc/BRIEF.md
# Overload Recovery Gain and Clip Stage

This block sits after a decimation filter and applies a programmable digital gain to each signed 12-bit sample, then rounds and hard-limits the result back into the signed 12-bit range. Because the stage saturates instead of wrapping, an overdriven input produces a clean rail value rather than a sign-flipped artefact. A small register file sets how the stage behaves. It holds the clamp level code that is sent to an external analog clamp, a custom-gain enable, a gain value and a sticky clip indicator.

A mode controller has two named states, NORMAL and RECOVERY. The ENTER transition goes from NORMAL to RECOVERY. It is taken when the control register at address 0x04 is written with bit 4 set. The EXIT transition goes from RECOVERY to NORMAL. It is taken when the same register is written with bit 4 clear. Each transition reloads the gain register and the clamp level code with the defaults for the new state. A write to 0x04 that leaves bit 4 unchanged stays in the current state (the HOLD transition) and only updates the clamp code. The value in the gain register takes effect only while the custom-gain enable is set. Otherwise the stage uses the default gain for the current state.

Top module: `ovr_gain_clip`

## Requirements
- R1: After reset the block is in NORMAL (`recov_mode`=0), `clamp_code`=0xC, gain register=0x40, custom-gain enable=0, `ovl_flag`=0 and `dout_vld`=0.
- R2: ENTER: in NORMAL, a write to 0x04 with bit 4 = 1 moves the block to RECOVERY. From the next cycle `recov_mode`=1, `clamp_code`=0x9 and the gain register reads 0x56. Written bits [3:0] are ignored on this write.
- R3: EXIT: in RECOVERY, a write to 0x04 with bit 4 = 0 moves the block to NORMAL. From the next cycle `recov_mode`=0, `clamp_code`=0xC and the gain register reads 0x40.
- R4: HOLD: a write to 0x04 whose bit 4 equals the current mode loads bits [3:0] into `clamp_code`. The state and the gain register are left unchanged.
- R5: Bit 7 of register 0x14 is the custom-gain enable. A write to register 0x15 (the gain, unsigned Q2.6) is ignored while the enable is 0 and stored while it is 1. The effective gain is the gain register when the enable is 1. When the enable is 0 it is 0x40 in NORMAL and 0x56 in RECOVERY.
- R6: For each valid sample, `dout` = floor((din*gain + 32)/64), which rounds half toward plus infinity. The result saturates to +2047 above the range and to -2048 below it.
- R7: `ovl_flag` is set in the cycle a saturated sample appears on `dout`. It stays set until a write to 0x14 with bit 6 = 1 clears it. It reads back as bit 6 of 0x14.
- R8: A sample presented with `din_vld` appears on `dout`, with `dout_vld`=1, exactly two clocks later. While `dout_vld` is 0, `dout` keeps its last value.
- R9: `rd_data` is combinational. It reads {3'b0, mode, clamp} at 0x04, {enable, flag, 6'b0} at 0x14, the gain register at 0x15, and 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| din | input | 12 | Signed input sample |
| din_vld | input | 1 | Input sample valid |
| dout | output | 12 | Signed gained and saturated sample |
| dout_vld | output | 1 | Output sample valid |
| clamp_code | output | 4 | Clamp level code for the analog clamp |
| recov_mode | output | 1 | 1 while in RECOVERY |
| ovl_flag | output | 1 | Sticky clip indicator |

## Verification
A register write at a rising edge is visible on `recov_mode`, `clamp_code` and `rd_data` one clock later. The bench therefore issues each write over one edge and reads the result at the falling edge that follows. A sample is due on `dout` two edges after it is presented, and `ovl_flag` rises in the same cycle. The bench checks that `dout_vld` is still low at the falling edge after the first edge. It then compares `dout` and the flag at the falling edge after the second edge, against values computed from the rounding and saturation rule in R6.

// File: rtl/ogc_pkg.sv
package ogc_pkg;
    localparam int REG_W   = 8;
    localparam logic [7:0] ADDR_OVL  = 8'h04;
    localparam logic [7:0] ADDR_CLIP = 8'h14;
    localparam logic [7:0] ADDR_GAIN = 8'h15;
    localparam int MODE_BIT = 4;
    localparam int CGS_BIT  = 7;
    localparam int FLAG_BIT = 6;

    typedef enum logic {
        ST_NORMAL   = 1'b0,
        ST_RECOVERY = 1'b1
    } mode_e;
endpackage

// File: rtl/ogc_regs.sv
module ogc_regs
    import ogc_pkg::*;
#(
    parameter int GW = 8,
    parameter int CW = 4,
    parameter logic [GW-1:0] NRM_GAIN  = 8'h40,
    parameter logic [GW-1:0] REC_GAIN  = 8'h56,
    parameter logic [CW-1:0] NRM_CLAMP = 4'hC,
    parameter logic [CW-1:0] REC_CLAMP = 4'h9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [7:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             clip_evt,
    output logic [GW-1:0]    gain_eff,
    output logic [CW-1:0]    clamp_code,
    output logic             recov_mode,
    output logic             ovl_flag
);
    mode_e          state_q, state_d;
    logic [CW-1:0]  clamp_q, clamp_d;
    logic [GW-1:0]  gain_q,  gain_d;
    logic           cgs_q,   cgs_d;
    logic           flag_q,  flag_d;

    logic ovl_wr, clip_wr, gain_wr;
    assign ovl_wr  = wr_en && (wr_addr == ADDR_OVL);
    assign clip_wr = wr_en && (wr_addr == ADDR_CLIP);
    assign gain_wr = wr_en && (wr_addr == ADDR_GAIN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            clamp_q <= NRM_CLAMP;
            gain_q  <= NRM_GAIN;
            cgs_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            clamp_q <= clamp_d;
            gain_q  <= gain_d;
            cgs_q   <= cgs_d;
            flag_q  <= flag_d;
        end
    end

    // next state and register updates
    always_comb begin
        state_d = state_q;
        clamp_d = clamp_q;
        gain_d  = gain_q;
        cgs_d   = cgs_q;
        flag_d  = flag_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (ovl_wr && wr_data[MODE_BIT]) begin          // ENTER
                    state_d = ST_RECOVERY;
                    clamp_d = REC_CLAMP;
                    gain_d  = REC_GAIN;
                end else if (ovl_wr) begin                       // HOLD
                    clamp_d = wr_data[CW-1:0];
                end
            end
            ST_RECOVERY: begin
                if (ovl_wr && !wr_data[MODE_BIT]) begin         // EXIT
                    state_d = ST_NORMAL;
                    clamp_d = NRM_CLAMP;
                    gain_d  = NRM_GAIN;
                end else if (ovl_wr) begin                       // HOLD
                    clamp_d = wr_data[CW-1:0];
                end
            end
            default: state_d = ST_NORMAL;
        endcase
        if (gain_wr && cgs_q) gain_d = wr_data[GW-1:0];
        if (clip_wr) begin
            cgs_d = wr_data[CGS_BIT];
            if (wr_data[FLAG_BIT]) flag_d = 1'b0;
        end
        if (clip_evt) flag_d = 1'b1;
    end

    // outputs
    always_comb begin
        recov_mode = (state_q == ST_RECOVERY);
        clamp_code = clamp_q;
        ovl_flag   = flag_q;
        if (cgs_q)
            gain_eff = gain_q;
        else if (state_q == ST_RECOVERY)
            gain_eff = REC_GAIN;
        else
            gain_eff = NRM_GAIN;
        rd_data = '0;
        unique case (rd_addr)
            ADDR_OVL: begin
                rd_data[MODE_BIT]  = recov_mode;
                rd_data[CW-1:0]    = clamp_q;
            end
            ADDR_CLIP: begin
                rd_data[CGS_BIT]   = cgs_q;
                rd_data[FLAG_BIT]  = flag_q;
            end
            ADDR_GAIN: rd_data[GW-1:0] = gain_q;
            default:   rd_data = '0;
        endcase
    end

    assert_enter_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_wr && wr_data[MODE_BIT] && state_q == ST_NORMAL)
        |=> (state_q == ST_RECOVERY && gain_q == REC_GAIN && clamp_q == REC_CLAMP));

    assert_exit_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_wr && !wr_data[MODE_BIT] && state_q == ST_RECOVERY)
        |=> (state_q == ST_NORMAL && gain_q == NRM_GAIN && clamp_q == NRM_CLAMP));

    assert_gain_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_wr && !cgs_q) |=> $stable(gain_q));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(clip_wr && wr_data[FLAG_BIT])) |=> flag_q);
endmodule

// File: rtl/ogc_mul.sv
module ogc_mul #(
    parameter int DW = 12,
    parameter int GW = 8,
    localparam int PW = DW + GW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        din,
    input  logic                 din_vld,
    input  logic [GW-1:0]        gain,
    output logic signed [PW-1:0] prod,
    output logic                 prod_vld
);
    logic signed [PW-1:0] prod_c;
    assign prod_c = $signed(din) * $signed({1'b0, gain});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod     <= '0;
            prod_vld <= 1'b0;
        end else begin
            prod_vld <= din_vld;
            if (din_vld) prod <= prod_c;
        end
    end
endmodule

// File: rtl/ogc_sat.sv
module ogc_sat #(
    parameter int DW   = 12,
    parameter int GW   = 8,
    parameter int FRAC = 6,
    localparam int PW  = DW + GW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [PW-1:0] prod,
    input  logic                 prod_vld,
    output logic [DW-1:0]        dout,
    output logic                 dout_vld,
    output logic                 clip_evt
);
    localparam logic signed [PW-1:0] MAXV = PW'((1 <<< (DW-1)) - 1);
    localparam logic signed [PW-1:0] MINV = -PW'(1 <<< (DW-1));
    localparam logic signed [PW-1:0] HALF = PW'(1 <<< (FRAC-1));

    logic signed [PW-1:0] rnd;
    logic                 over, under;
    logic [DW-1:0]        sat_c;

    always_comb begin
        rnd   = (prod + HALF) >>> FRAC;
        over  = rnd > MAXV;
        under = rnd < MINV;
        if (over)       sat_c = MAXV[DW-1:0];
        else if (under) sat_c = MINV[DW-1:0];
        else            sat_c = rnd[DW-1:0];
        clip_evt = prod_vld && (over || under);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= prod_vld;
            if (prod_vld) dout <= sat_c;
        end
    end

    assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_vld && over) |=> (dout == MAXV[DW-1:0]));

    assert_sat_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_vld && under) |=> (dout == MINV[DW-1:0]));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_vld |=> $stable(dout));
endmodule

// File: rtl/ovr_gain_clip.sv
module ovr_gain_clip #(
    parameter int DW   = 12,
    parameter int GW   = 8,
    parameter int FRAC = 6,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [7:0]    rd_addr,
    output logic [7:0]    rd_data,
    input  logic [DW-1:0] din,
    input  logic          din_vld,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic [CW-1:0] clamp_code,
    output logic          recov_mode,
    output logic          ovl_flag
);
    localparam int PW = DW + GW + 1;

    logic [GW-1:0]        gain_eff;
    logic signed [PW-1:0] prod;
    logic                 prod_vld;
    logic                 clip_evt;

    ogc_regs #(.GW(GW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .clip_evt(clip_evt), .gain_eff(gain_eff),
        .clamp_code(clamp_code), .recov_mode(recov_mode), .ovl_flag(ovl_flag)
    );

    ogc_mul #(.DW(DW), .GW(GW)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .din(din), .din_vld(din_vld), .gain(gain_eff),
        .prod(prod), .prod_vld(prod_vld)
    );

    ogc_sat #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_sat (
        .clk(clk), .rst_n(rst_n),
        .prod(prod), .prod_vld(prod_vld),
        .dout(dout), .dout_vld(dout_vld), .clip_evt(clip_evt)
    );

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld |=> ##1 dout_vld);

    assert_flag_on_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clip_evt |=> ovl_flag);
endmodule

// File: tb/ovr_gain_clip_tb.sv
module ovr_gain_clip_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [11:0] din = '0;
    logic        din_vld = 1'b0;
    logic [11:0] dout;
    logic        dout_vld;
    logic [3:0]  clamp_code;
    logic        recov_mode;
    logic        ovl_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    ovr_gain_clip u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .din(din), .din_vld(din_vld),
        .dout(dout), .dout_vld(dout_vld),
        .clamp_code(clamp_code), .recov_mode(recov_mode), .ovl_flag(ovl_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input int d, input int g);
        int r;
        r = (d * g + 32) >>> 6;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // present one sample and check it two clocks later
    task automatic sample(input string req, input int d, input int exp, input int exp_flag);
        @(negedge clk);
        din = 12'(d); din_vld = 1'b1;
        @(negedge clk);
        din_vld = 1'b0;
        check({req, " R8 not early"}, int'(dout_vld), 0);
        @(negedge clk);
        check({req, " R8 valid"}, int'(dout_vld), 1);
        check({req, " R6 data"}, int'($signed(dout)), exp);
        check({req, " R7 flag"}, int'(ovl_flag), exp_flag);
        @(negedge clk);
        check({req, " R8 hold"}, int'($signed(dout)), exp);
    endtask

    task automatic t_reset;
        int v;
        check("R1 mode", int'(recov_mode), 0);
        check("R1 clamp", int'(clamp_code), 12);
        check("R1 flag", int'(ovl_flag), 0);
        check("R1 dout_vld", int'(dout_vld), 0);
        rd(8'h15, v); check("R1 gain", v, 8'h40);
        rd(8'h14, v); check("R1 clip reg", v, 0);
    endtask

    task automatic t_normal_path;
        sample("R6 unity", 100, model(100, 64), 0);
        sample("R6 unity neg", -2048, model(-2048, 64), 0);
    endtask

    task automatic t_hold_clamp;
        int v;
        wr(8'h04, 8'h03);
        check("R4 clamp", int'(clamp_code), 3);
        check("R4 mode", int'(recov_mode), 0);
        rd(8'h15, v); check("R4 gain", v, 8'h40);
    endtask

    task automatic t_enter;
        int v;
        wr(8'h04, 8'h1F);
        check("R2 mode", int'(recov_mode), 1);
        check("R2 clamp", int'(clamp_code), 9);
        rd(8'h15, v); check("R2 gain", v, 8'h56);
        rd(8'h04, v); check("R9 r04", v, 8'h19);
        sample("R2 gain use", 1000, model(1000, 86), 0);
    endtask

    task automatic t_clip;
        int v;
        sample("R6 clip high", 2000, 2047, 1);
        sample("R7 sticky", 10, model(10, 86), 1);
        rd(8'h14, v); check("R7 flag readback", v, 8'h40);
        wr(8'h14, 8'h40);
        check("R7 clear", int'(ovl_flag), 0);
        sample("R6 clip low", -2048, -2048, 1);
        wr(8'h14, 8'h40);
    endtask

    task automatic t_gain_lock;
        int v;
        wr(8'h15, 8'h60);
        rd(8'h15, v); check("R5 ignored", v, 8'h56);
        sample("R5 ignored path", 64, model(64, 86), 0);
        wr(8'h14, 8'h80);
        wr(8'h15, 8'h60);
        rd(8'h15, v); check("R5 stored", v, 8'h60);
        sample("R6 round pos", 3, model(3, 96), 0);
        sample("R6 round neg", -3, model(-3, 96), 0);
        wr(8'h14, 8'h00);
        sample("R5 default when off", 64, model(64, 86), 0);
    endtask

    task automatic t_exit;
        int v;
        wr(8'h04, 8'h05);
        check("R3 mode", int'(recov_mode), 0);
        check("R3 clamp", int'(clamp_code), 12);
        rd(8'h15, v); check("R3 gain", v, 8'h40);
        rd(8'h33, v); check("R9 unmapped", v, 0);
        wr(8'h14, 8'h80);
        wr(8'h15, 8'hFF);
        sample("R6 max gain", 2047, 2047, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal_path();
        t_hold_clamp();
        t_enter();
        t_clip();
        t_gain_lock();
        t_exit();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule